// File: doc/BRIEF.md
# SPI Master with Per-Frame Attribute Sets

This block is an SPI shift engine that keeps a table of eight programmable transfer-attribute sets. Every command word that enters through a valid/ready port carries a 3-bit set selector, a counter-clear bit and up to 16 data bits. When the engine takes a word, the set it selects fixes that frame's clock polarity, clock phase, bit order, frame length (4 to 16 bits) and SCK rate. Data shifts out on `mosi` while `miso` is captured. The received word is presented right-justified with a one-cycle strobe.

A 16-bit frame counter counts finished frames and wraps at its top. Software can preset it through the register write port. A command can also clear it when its frame begins. The same write port programs the attribute table. Table writes that arrive while a frame is in flight are dropped and reported on an error strobe. With `mode_slave` high, the selector is ignored and set 0 governs every frame. In that mode the pins still behave as described here, because slave-side pin handling lies outside this block.

Register map on `wr_addr`: 0 to 7 select attribute sets and 8 selects the counter. Other addresses are ignored. Attribute word layout on `wr_data`: [3:0] frame length minus one, where values below 3 are raised to 3. [7:4] is the baud field B. [8] is idle SCK level (polarity). [9] is phase. [10] selects LSB-first when 1.

Top module: `spi_attr_master`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs take these values: `cs_n`=1, `sck`=0, `mosi`=0, `cmd_ready`=1, `rx_valid`=0, `rx_data`=0, `xfer_cnt`=0 and `wr_err`=0. All eight sets reset to an 8-bit frame, MSB first, polarity 0, phase 0 and B=0.
- R2: In master mode (`mode_slave`=0), the frame uses the set numbered by `cmd_sel[2:0]`. With `mode_slave`=1, set 0 is used whatever `cmd_sel` holds.
- R3: A frame of N bits (N = field+1, at least 4) makes exactly 2N SCK transitions.
- R4: The SCK half-period is H=(B+1)*2 clocks. `cs_n` falls in the cycle the command is accepted. The first SCK transition comes H cycles later, and successive transitions are H cycles apart. `cs_n` rises H cycles after the last transition, so it stays low for (2N+1)*H cycles.
- R5: After `cs_n` rises, `cmd_ready` stays low for a further 2H cycles. `cmd_ready` is high only when no frame is active.
- R6: With phase 0, the first bit is on `mosi` from the accept cycle on. Odd-numbered SCK transitions sample `miso`, and even-numbered transitions other than the last present the next bit. With phase 1, `mosi` is 0 until the first transition. Odd-numbered transitions present bits, and even-numbered transitions sample. `mosi` is 0 whenever `cs_n` is high.
- R7: MSB-first sends data bit N-1 first and LSB-first sends bit 0 first. Only bits N-1..0 of `cmd_data` are sent. The received bits land at the same positions, and the upper bits of `rx_data` are 0. `rx_data` updates and `rx_valid` pulses for one cycle in the cycle `cs_n` rises.
- R8: While `cs_n` is high, `sck` holds steady at the polarity of the last frame (0 after reset).
- R9: A write to address 0..7 while `cmd_ready` is low leaves the table unchanged, and `wr_err` is 1 in the following cycle only. Otherwise `wr_err` is 0.
- R10: `xfer_cnt` increments in the cycle `cs_n` rises at the end of each frame, and it wraps from 65535 to 0.
- R11: A write to address 8 loads `wr_data` into the counter in the next cycle. It takes priority over a frame-end increment or a command clear in the same cycle.
- R12: A command accepted with `cmd_clr_cnt`=1 sets the counter to 0 in its accept cycle. The frame's own increment then follows at its end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_slave | input | 1 | Forces attribute set 0 for every frame |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address: 0..7 sets, 8 counter |
| wr_data | input | 16 | Register write data |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Engine idle, command taken when valid |
| cmd_sel | input | 3 | Attribute set selector |
| cmd_clr_cnt | input | 1 | Clear counter when this frame starts |
| cmd_data | input | 16 | Transmit data, right-justified |
| miso | input | 1 | Serial data in (synchronous to clk) |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Chip select, active low |
| rx_valid | output | 1 | One-cycle strobe with received data |
| rx_data | output | 16 | Received word, right-justified |
| xfer_cnt | output | 16 | Completed-frame counter |
| wr_err | output | 1 | Table write rejected while busy |

## Verification
Two counter updates can land on the same clock edge. A counter preset can meet the frame-end increment, and a counter preset can meet a command whose clear bit is set. The bench provokes the first case by counting (2N+1)*H cycles from the accept edge of a short frame and asserting the write exactly on the edge where `cs_n` rises. It provokes the second case by offering the command and the counter write in the same cycle. Both outcomes are judged against a behavioural model: the loaded value must appear unchanged, with no +1 added and no clear applied, while `cs_n` and `rx_valid` still show that the frame ended on that very edge.

// File: rtl/spi_attr_pkg.sv
// Shared constants, attribute record and engine state encoding for the
// per-frame-attribute SPI master. Assumes a 16-bit register write port.
package spi_attr_pkg;
    localparam int NUM_SETS   = 8;
    localparam int SEL_W      = $clog2(NUM_SETS);
    localparam int DATA_W     = 16;
    localparam int CNT_W      = 16;
    localparam int REG_W      = 16;
    localparam int ADDR_W     = 4;
    localparam int DIV_W      = 4;
    localparam int SIZE_W     = 4;
    localparam int MIN_BITS   = 4;
    localparam int ATTR_W     = SIZE_W + DIV_W + 3;
    localparam int CNT_ADDR   = NUM_SETS;

    // One transfer-attribute set; size_m1 holds frame length minus one.
    typedef struct packed {
        logic              lsb_first;
        logic              cpha;
        logic              cpol;
        logic [DIV_W-1:0]  div;
        logic [SIZE_W-1:0] size_m1;
    } attr_t;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_LEAD  = 2'd1,
        ENG_SHIFT = 2'd2,
        ENG_GAP   = 2'd3
    } eng_state_e;

    localparam attr_t ATTR_RESET = '{lsb_first: 1'b0, cpha: 1'b0, cpol: 1'b0,
                                     div: '0, size_m1: SIZE_W'(7)};

    // Unpack a register word into an attribute set, raising short sizes.
    function automatic attr_t unpack_attr(input logic [ATTR_W-1:0] w);
        attr_t a;
        a.size_m1   = w[SIZE_W-1:0];
        a.div       = w[SIZE_W +: DIV_W];
        a.cpol      = w[SIZE_W+DIV_W];
        a.cpha      = w[SIZE_W+DIV_W+1];
        a.lsb_first = w[SIZE_W+DIV_W+2];
        if (a.size_m1 < SIZE_W'(MIN_BITS-1))
            a.size_m1 = SIZE_W'(MIN_BITS-1);
        return a;
    endfunction
endpackage

// File: rtl/spi_attr_table.sv
// Attribute table: holds NSETS attribute sets written through the register
// port. Writes are refused while the engine is busy and flagged on wr_err
// one cycle later. The read port is combinational from the stored sets, so a
// frame accepted in the same cycle as a write sees the old contents.
module spi_attr_table
    import spi_attr_pkg::*;
#(
    parameter int NSETS = NUM_SETS,
    parameter int SW    = SEL_W,
    parameter int AW    = ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [ATTR_W-1:0] wr_word,
    input  logic              busy,
    input  logic [SW-1:0]     rd_sel,
    output attr_t             rd_attr,
    output logic              wr_err
);
    attr_t            sets_q [NSETS];
    logic [NSETS-1:0] hit;
    logic             any_hit;

    // Per-set address decode of the write strobe.
    for (genvar g = 0; g < NSETS; g++) begin : g_dec
        assign hit[g] = wr_en && (wr_addr == AW'(g));
    end
    assign any_hit = |hit;

    // Store accepted writes; the table is frozen while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSETS; i++) sets_q[i] <= ATTR_RESET;
        end else if (!busy) begin
            for (int i = 0; i < NSETS; i++)
                if (hit[i]) sets_q[i] <= unpack_attr(wr_word);
        end
    end

    // Flag a table write that arrived during a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_err <= 1'b0;
        else        wr_err <= any_hit && busy;
    end

    // Combinational read of the selected set.
    assign rd_attr = sets_q[rd_sel];
endmodule

// File: rtl/spi_xfer_counter.sv
// Completed-frame counter with preset, clear-at-start and increment.
// Preset wins over everything; clear and increment may both apply.
module spi_xfer_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         clear,
    input  logic         incr,
    output logic [W-1:0] count
);
    logic [W-1:0] base;

    // Starting point for this cycle: zero when cleared.
    assign base = clear ? '0 : count;

    // Counter register; natural wrap of the W-bit sum.
    always_ff @(posedge clk) begin
        if (!rst_n)     count <= '0;
        else if (load)  count <= load_val;
        else if (incr)  count <= base + W'(1);
        else if (clear) count <= '0;
    end
endmodule

// File: rtl/spi_frame_engine.sv
// Frame engine: takes one command when idle, latches its attribute set and
// runs chip select, SCK, MOSI and MISO sampling from a single half-period
// timer. Assumes miso is already synchronous to clk. frame_end is high in
// the cycle whose edge raises cs_n.
module spi_frame_engine
    import spi_attr_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_valid,
    output logic          start_ready,
    input  attr_t         start_attr,
    input  logic [DW-1:0] start_data,
    input  logic          miso,
    output logic          sck,
    output logic          mosi,
    output logic          cs_n,
    output logic          rx_valid,
    output logic [DW-1:0] rx_data,
    output logic          frame_end
);
    localparam int BIT_W  = $clog2(DW);
    localparam int EDGE_W = $clog2(2*DW + 1);
    localparam int TMR_W  = DIV_W + 3;

    eng_state_e         st_q;
    attr_t              cur_q;
    logic [DW-1:0]      tx_q;
    logic [DW-1:0]      rx_q;
    logic [TMR_W-1:0]   tmr_q;
    logic [EDGE_W-1:0]  ecnt_q;
    logic [BIT_W-1:0]   drv_q;
    logic [BIT_W-1:0]   smp_q;

    logic [TMR_W-1:0]   half_cur;
    logic [TMR_W-1:0]   half_new;
    logic [EDGE_W-1:0]  edges_tot;
    logic               tmr_done;
    logic               sample_edge;
    logic               final_edge;
    logic               accept;

    // SCK half-period in system clocks for a given attribute set.
    function automatic logic [TMR_W-1:0] half_of(input attr_t a);
        return (TMR_W'(a.div) + TMR_W'(1)) << 1;
    endfunction

    // Data bit index for the idx-th bit on the wire.
    function automatic logic [BIT_W-1:0] slot_of(input attr_t a,
                                                 input logic [BIT_W-1:0] idx);
        return a.lsb_first ? idx : (BIT_W'(a.size_m1) - idx);
    endfunction

    // Derived timing quantities for the running frame.
    always_comb begin
        half_cur    = half_of(cur_q);
        half_new    = half_of(start_attr);
        edges_tot   = (EDGE_W'(cur_q.size_m1) + EDGE_W'(1)) << 1;
        tmr_done    = (tmr_q == '0);
        sample_edge = (~ecnt_q[0]) ^ cur_q.cpha;
        final_edge  = (ecnt_q + EDGE_W'(1)) == edges_tot;
    end

    assign start_ready = (st_q == ENG_IDLE);
    assign accept      = start_ready && start_valid;
    assign frame_end   = (st_q == ENG_SHIFT) && tmr_done && (ecnt_q == edges_tot);

    // Frame sequencer: lead-in, SCK edges, end of frame and idle gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ENG_IDLE;
            cur_q    <= ATTR_RESET;
            tx_q     <= '0;
            rx_q     <= '0;
            tmr_q    <= '0;
            ecnt_q   <= '0;
            drv_q    <= '0;
            smp_q    <= '0;
            sck      <= 1'b0;
            mosi     <= 1'b0;
            cs_n     <= 1'b1;
            rx_valid <= 1'b0;
            rx_data  <= '0;
        end else begin
            rx_valid <= 1'b0;
            case (st_q)
                ENG_IDLE: begin
                    if (accept) begin
                        cur_q  <= start_attr;
                        tx_q   <= start_data;
                        rx_q   <= '0;
                        cs_n   <= 1'b0;
                        sck    <= start_attr.cpol;
                        tmr_q  <= half_new - TMR_W'(1);
                        ecnt_q <= '0;
                        smp_q  <= '0;
                        st_q   <= ENG_LEAD;
                        if (!start_attr.cpha) begin
                            mosi  <= start_data[slot_of(start_attr, '0)];
                            drv_q <= BIT_W'(1);
                        end else begin
                            mosi  <= 1'b0;
                            drv_q <= '0;
                        end
                    end
                end
                ENG_LEAD, ENG_SHIFT: begin
                    if (!tmr_done) begin
                        tmr_q <= tmr_q - TMR_W'(1);
                    end else if (frame_end) begin
                        cs_n     <= 1'b1;
                        mosi     <= 1'b0;
                        rx_data  <= rx_q;
                        rx_valid <= 1'b1;
                        tmr_q    <= (half_cur << 1) - TMR_W'(1);
                        st_q     <= ENG_GAP;
                    end else begin
                        sck    <= ~sck;
                        ecnt_q <= ecnt_q + EDGE_W'(1);
                        tmr_q  <= half_cur - TMR_W'(1);
                        st_q   <= ENG_SHIFT;
                        if (sample_edge) begin
                            rx_q[slot_of(cur_q, smp_q)] <= miso;
                            smp_q <= smp_q + BIT_W'(1);
                        end else if (!final_edge) begin
                            mosi  <= tx_q[slot_of(cur_q, drv_q)];
                            drv_q <= drv_q + BIT_W'(1);
                        end
                    end
                end
                ENG_GAP: begin
                    if (!tmr_done) tmr_q <= tmr_q - TMR_W'(1);
                    else           st_q  <= ENG_IDLE;
                end
                default: st_q <= ENG_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spi_attr_master.sv
// Top level: attribute table, frame engine and frame counter. Selector is
// overridden to set 0 in slave mode. Register address NUM_SETS is the counter.
module spi_attr_master
    import spi_attr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_slave,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [SEL_W-1:0]  cmd_sel,
    input  logic              cmd_clr_cnt,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic              cs_n,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic [CNT_W-1:0]  xfer_cnt,
    output logic              wr_err
);
    logic [SEL_W-1:0] sel_eff;
    attr_t            sel_attr;
    logic             frame_end;
    logic             cnt_load;
    logic             cnt_clear;

    // Slave mode pins the selector to set 0.
    assign sel_eff   = mode_slave ? '0 : cmd_sel;
    assign cnt_load  = wr_en && (wr_addr == ADDR_W'(CNT_ADDR));
    assign cnt_clear = cmd_valid && cmd_ready && cmd_clr_cnt;

    spi_attr_table #(.NSETS(NUM_SETS), .SW(SEL_W), .AW(ADDR_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_word (wr_data[ATTR_W-1:0]),
        .busy    (~cmd_ready),
        .rd_sel  (sel_eff),
        .rd_attr (sel_attr),
        .wr_err  (wr_err)
    );

    spi_frame_engine #(.DW(DATA_W)) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_valid (cmd_valid),
        .start_ready (cmd_ready),
        .start_attr  (sel_attr),
        .start_data  (cmd_data),
        .miso        (miso),
        .sck         (sck),
        .mosi        (mosi),
        .cs_n        (cs_n),
        .rx_valid    (rx_valid),
        .rx_data     (rx_data),
        .frame_end   (frame_end)
    );

    spi_xfer_counter #(.W(CNT_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (wr_data[CNT_W-1:0]),
        .clear    (cnt_clear),
        .incr     (frame_end),
        .count    (xfer_cnt)
    );
endmodule

// File: rtl/spi_attr_master_chk.sv
// Port-level temporal checks for spi_attr_master, bound to every instance.
module spi_attr_master_chk
    import spi_attr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [REG_W-1:0]  wr_data,
    input logic              cmd_ready,
    input logic              sck,
    input logic              mosi,
    input logic              cs_n,
    input logic              rx_valid,
    input logic [CNT_W-1:0]  xfer_cnt,
    input logic              wr_err
);
    a_r8_sck_still_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n)) |-> $stable(sck));

    a_r6_mosi_low_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !mosi);

    a_r5_ready_only_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> cs_n);

    a_r7_strobe_with_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (cs_n && !$past(cs_n)));

    a_r9_err_means_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> ($past(wr_en) && ($past(wr_addr) < ADDR_W'(NUM_SETS)) && !$past(cmd_ready)));

    a_r10_count_on_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cs_n) && !($past(wr_en) && $past(wr_addr) == ADDR_W'(CNT_ADDR)))
        |-> (xfer_cnt == $past(xfer_cnt) + CNT_W'(1)));

    a_r11_preset_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en) && $past(wr_addr) == ADDR_W'(CNT_ADDR))
        |-> (xfer_cnt == $past(wr_data[CNT_W-1:0])));
endmodule

bind spi_attr_master spi_attr_master_chk chk_i (.*);

// File: tb/spi_attr_master_tb.sv
`timescale 1ns/1ps
module spi_attr_master_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_slave = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [2:0]  cmd_sel = '0;
    logic        cmd_clr_cnt = 1'b0;
    logic [15:0] cmd_data = '0;
    logic        miso = 1'b0;
    logic        sck, mosi, cs_n, rx_valid, wr_err;
    logic [15:0] rx_data, xfer_cnt;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit armed = 0;
    int low_run = 0;
    int last_low = 0;

    always #4 clk = ~clk;

    spi_attr_master dut_i (.*);

    // Reference model state.
    int m_n[8], m_h[8], m_pol[8], m_pha[8], m_lsb[8];
    bit m_active;
    int m_d, fN, fH, fpol, fpha, flsb;
    logic [15:0] fdata, m_rxw, m_rxd, m_cnt;
    bit m_rxv, m_err, m_idle_sck;

    function automatic int slot(int b);
        return (flsb != 0) ? b : fN - 1 - b;
    endfunction

    task automatic model_set(int i, logic [15:0] w);
        int sz;
        sz = int'(w[3:0]) + 1;
        if (sz < 4) sz = 4;
        m_n[i] = sz;
        m_h[i] = (int'(w[7:4]) + 1) * 2;
        m_pol[i] = int'(w[8]);
        m_pha[i] = int'(w[9]);
        m_lsb[i] = int'(w[10]);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Behavioural model step on each rising edge.
    always @(posedge clk) begin : model
        bit pre_ready, fr_end;
        int k, s, si;
        logic [15:0] nc;
        cyc++;
        if (cyc > 100000) begin
            n_bad++;
            $display("FAIL R5 watchdog: actual=hung expected=completion");
            summary();
        end
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) model_set(i, 16'h0007);
            m_active = 0; m_d = 0; m_rxw = '0; m_rxd = '0; m_cnt = '0;
            m_rxv = 0; m_err = 0; m_idle_sck = 0;
            armed = 1;
        end else begin
            pre_ready = !m_active;
            fr_end = 0;
            m_rxv = 0;
            m_err = 0;
            if (m_active) begin
                m_d++;
                if (m_d % fH == 0) begin
                    k = m_d / fH;
                    if (k >= 1 && k <= 2*fN && ((k % 2 == 1) != (fpha == 1))) begin
                        s = (fpha == 1) ? k/2 - 1 : (k-1)/2;
                        m_rxw[slot(s)] = miso;
                    end
                end
                if (m_d == (2*fN+1)*fH) begin
                    m_rxv = 1; m_rxd = m_rxw; fr_end = 1;
                end
                if (m_d == (2*fN+3)*fH) m_active = 0;
            end
            nc = m_cnt;
            if (pre_ready && cmd_valid) begin
                si = mode_slave ? 0 : int'(cmd_sel);
                fN = m_n[si]; fH = m_h[si]; fpol = m_pol[si];
                fpha = m_pha[si]; flsb = m_lsb[si];
                fdata = cmd_data; m_rxw = '0; m_d = 0; m_active = 1;
                m_idle_sck = fpol[0];
                if (cmd_clr_cnt) nc = '0;
            end
            if (fr_end) nc = nc + 16'd1;
            if (wr_en && wr_addr == 4'd8) nc = wr_data;
            m_cnt = nc;
            if (wr_en && wr_addr < 4'd8) begin
                if (pre_ready) model_set(int'(wr_addr), wr_data);
                else m_err = 1;
            end
        end
    end

    task automatic cmp1(string tag, string nm, int act, int exp);
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s at cycle %0d: actual=%0h expected=%0h", tag, nm, cyc, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison, away from the active edge.
    always @(negedge clk) begin : compare
        int t, b;
        bit ecs, esck, emosi;
        if (!cs_n) low_run++;
        else if (low_run != 0) begin last_low = low_run; low_run = 0; end
        if (armed && rst_n) begin
            if (m_active && m_d < (2*fN+1)*fH) begin
                ecs = 0;
                t = m_d / fH;
                esck = fpol[0] ^ t[0];
                if (fpha == 0) begin
                    b = (t/2 < fN-1) ? t/2 : fN-1;
                    emosi = fdata[slot(b)];
                end else begin
                    emosi = (t == 0) ? 1'b0 : fdata[slot((t-1)/2)];
                end
            end else begin
                ecs = 1; esck = m_idle_sck; emosi = 0;
            end
            n_cmp++;
            cmp1("R4", "cs_n", int'(cs_n), int'(ecs));
            cmp1("R3", "sck", int'(sck), int'(esck));
            cmp1("R6", "mosi", int'(mosi), int'(emosi));
            cmp1("R5", "cmd_ready", int'(cmd_ready), int'(!m_active));
            cmp1("R7", "rx_valid", int'(rx_valid), int'(m_rxv));
            cmp1("R7", "rx_data", int'(rx_data), int'(m_rxd));
            cmp1("R10", "xfer_cnt", int'(xfer_cnt), int'(m_cnt));
            cmp1("R9", "wr_err", int'(wr_err), int'(m_err));
        end
    end

    // Random serial input, changed away from the sampling edge.
    always @(negedge clk) miso <= 1'($urandom_range(0, 1));

    task automatic check(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic reg_wr(logic [3:0] a, logic [15:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic send(logic [2:0] sel, bit clr, logic [15:0] d);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1; cmd_sel = sel; cmd_clr_cnt = clr; cmd_data = d;
        @(negedge clk);
        cmd_valid = 0; cmd_clr_cnt = 0;
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check("R1", "cs_n at reset", int'(cs_n), 1);
        check("R1", "sck at reset", int'(sck), 0);
        check("R1", "mosi at reset", int'(mosi), 0);
        check("R1", "ready at reset", int'(cmd_ready), 1);
        check("R1", "count at reset", int'(xfer_cnt), 0);
        rst_n = 1;
        @(negedge clk);

        // Default set: 8 bits, H=2 -> cs low 34 cycles.
        send(3'd5, 0, 16'h00A5); wait_done();
        check("R4", "low length default set", last_low, 34);

        reg_wr(4'd0, 16'h0007);
        reg_wr(4'd1, 16'h071F);
        reg_wr(4'd2, 16'h0201);
        reg_wr(4'd3, 16'h052B);
        reg_wr(4'd7, 16'h00F4);

        send(3'd1, 0, 16'hC3A5); wait_done();
        check("R3", "16-bit lsb frame low length", last_low, 132);
        check("R8", "idle sck follows polarity 1", int'(sck), 1);
        send(3'd2, 0, 16'hFFF9); wait_done();
        check("R3", "clamped 4-bit frame low length", last_low, 18);
        check("R8", "idle sck follows polarity 0", int'(sck), 0);
        send(3'd3, 0, 16'h5A5A); wait_done();
        check("R4", "12-bit frame at H=6", last_low, 150);
        send(3'd7, 0, 16'h0013); wait_done();
        check("R4", "5-bit frame at H=32", last_low, 352);

        mode_slave = 1;
        send(3'd1, 0, 16'h0081); wait_done();
        check("R2", "slave mode uses set 0", last_low, 34);
        mode_slave = 0;
        send(3'd3, 0, 16'h0F0F); wait_done();
        check("R2", "selector picks set 3", last_low, 150);

        // Busy write to set 1 is refused and flagged.
        send(3'd1, 0, 16'h1234);
        repeat (5) @(negedge clk);
        reg_wr(4'd1, 16'h0007);
        check("R9", "wr_err after busy write", int'(wr_err), 1);
        @(negedge clk);
        check("R9", "wr_err is one cycle", int'(wr_err), 0);
        wait_done();
        send(3'd1, 0, 16'h4321); wait_done();
        check("R9", "set 1 kept after refused write", last_low, 132);

        // Wrap and clear-at-start.
        reg_wr(4'd8, 16'hFFFF);
        check("R11", "preset loads", int'(xfer_cnt), 16'hFFFF);
        send(3'd2, 0, 16'h0006); wait_done();
        check("R10", "wrap to zero", int'(xfer_cnt), 0);
        reg_wr(4'd8, 16'h0100);
        send(3'd2, 1, 16'h0003);
        check("R12", "cleared at accept", int'(xfer_cnt), 0);
        wait_done();
        check("R12", "increment after clear", int'(xfer_cnt), 1);

        // Preset on the frame-end edge of an 8-bit, H=2 frame.
        send(3'd0, 0, 16'h0099);
        repeat (33) @(negedge clk);
        reg_wr(4'd8, 16'h2222);
        check("R11", "cs_n rose on preset edge", int'(cs_n), 1);
        check("R11", "preset beats increment", int'(xfer_cnt), 16'h2222);
        wait_done();

        // Preset together with a clearing command.
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1; cmd_sel = 3'd2; cmd_clr_cnt = 1; cmd_data = 16'h000C;
        wr_en = 1; wr_addr = 4'd8; wr_data = 16'h0777;
        @(negedge clk);
        cmd_valid = 0; cmd_clr_cnt = 0; wr_en = 0;
        check("R11", "preset beats clear", int'(xfer_cnt), 16'h0777);
        wait_done();
        check("R10", "increment after preset", int'(xfer_cnt), 16'h0778);

        repeat (5) @(negedge clk);
        summary();
    end
endmodule